// File: doc/BRIEF.md
# T-box AES Encryption Round

This block computes one AES encryption round on a 128-bit state in a single clock cycle. Four lookup tables replace the separate byte substitution, row shift and column mixing steps. Each table has 256 words of 32 bits and is addressed by one state byte. Each output column is the XOR of four table words and one round-key word.

A last-round flag selects a different path that skips the column mix. On that path each output byte is taken from a table byte whose mixing coefficient is one. The result is the plain substituted byte, so no separate S-box table is needed.

The table contents are computed at elaboration from field arithmetic, and no file is loaded. An external controller supplies the round keys and counts the rounds. The result is registered, so each round takes one cycle of latency.

Top module: `aes_tbox_round`

## Requirements
- R1: While reset is asserted, `valid_o` is 0 and `state_o` is all zeros.
- R2: `valid_o` is 1 in the cycle after a cycle in which `valid_i` was 1. It is 0 after a cycle in which `valid_i` was 0.
- R3: When `valid_i` is 0, `state_o` keeps its previous value.
- R4: Byte ordering of the state: column c, row r is the byte at bits `[127-8*(4c+r) -: 8]`. With `last_i` = 0, the output is byte substitution, then row shift, then column mix, then XOR with `rkey_i`. Column mix uses coefficients 02,03,01,01 in rotated order over GF(2^8) with polynomial 0x11B.
- R5: Output column j, row r takes its source byte from input column (j+r) mod 4, row r.
- R6: With `last_i` = 1, the output is byte substitution, then row shift, then XOR with `rkey_i`. No column mix is applied. An all-zero state with an all-zero key gives sixteen bytes of 0x63.
- R7: The round key enters only as an XOR. For the same state and flag, two different keys give outputs that differ by exactly the XOR of the two keys.
- R8: Take the standard AES-128 example: plaintext 3243f6a8885a308d313198a2e0370734 and key 2b7e151628aed2a6abf7158809cf4f3c. XOR the plaintext with the key, then run rounds 1 to 9 with `last_i` = 0 and round 10 with `last_i` = 1. The result is ciphertext 3925841d02dc09fbdc118597196a0b32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input state and key are valid this cycle |
| last_i | input | 1 | Final round: skip the column mix |
| state_i | input | 128 | Round input state |
| rkey_i | input | 128 | Round key |
| valid_o | output | 1 | Registered result is valid |
| state_o | output | 128 | Registered round output |

## Verification
Each round result and its valid strobe appear at the first rising edge after the inputs are accepted. The bench drives inputs on the falling edge and samples `state_o` and `valid_o` at the next falling edge, half a cycle after that registering edge. One further falling edge later, with `valid_i` low, it confirms that the strobe has dropped and the state is held. For the chained example, each round's sampled output is fed back as the next round's input, and every intermediate state is compared against an independent reference model.

// File: rtl/aes_tbox_pkg.sv
package aes_tbox_pkg;
  localparam int BYTE_W  = 8;
  localparam int ROWS    = 4;
  localparam int COLS    = 4;
  localparam int WORD_W  = BYTE_W * ROWS;
  localparam int STATE_W = WORD_W * COLS;
  localparam int TBL_N   = 1 << BYTE_W;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // a^254 by square-and-multiply; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] p, r;
    p = a;
    r = 8'h01;
    for (int k = 1; k < 8; k++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return 8'((b << n) | (b >> (8 - n)));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // table rot: base word {02,01,01,03}*S rotated down by rot bytes
  function automatic logic [WORD_W-1:0] tbox_entry(input int rot, input logic [7:0] a);
    logic [7:0] s, s2;
    logic [WORD_W-1:0] w;
    s  = sbox(a);
    s2 = xtime(s);
    w  = {s2, s, s, s2 ^ s};
    for (int i = 0; i < rot; i++) w = {w[7:0], w[WORD_W-1:8]};
    return w;
  endfunction
endpackage

// File: rtl/aes_tbox_rom.sv
module aes_tbox_rom
  import aes_tbox_pkg::*;
#(
  parameter int ROT   = 0,
  parameter int PORTS = COLS
) (
  input  logic [PORTS*BYTE_W-1:0] idx_i,
  output logic [PORTS*WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] rom [TBL_N];

  for (genvar i = 0; i < TBL_N; i++) begin : g_fill
    assign rom[i] = tbox_entry(ROT, BYTE_W'(i));
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign word_o[p*WORD_W +: WORD_W] = rom[idx_i[p*BYTE_W +: BYTE_W]];
  end
endmodule

// File: rtl/aes_tbox_column.sv
module aes_tbox_column
  import aes_tbox_pkg::*;
(
  input  logic [ROWS-1:0][WORD_W-1:0] tw_i,   // tw_i[t] = word from table t
  input  logic [WORD_W-1:0]           key_i,
  input  logic                        last_i,
  output logic [WORD_W-1:0]           col_o
);
  logic [WORD_W-1:0] mix_w, sub_w;

  always_comb begin
    mix_w = '0;
    for (int t = 0; t < ROWS; t++) mix_w = mix_w ^ tw_i[t];
  end

  // row t takes the coefficient-01 byte of table t, found in row (t+1) mod 4
  for (genvar t = 0; t < ROWS; t++) begin : g_sub
    localparam int SRC_ROW = (t + 1) % ROWS;
    assign sub_w[WORD_W-1-BYTE_W*t -: BYTE_W] = tw_i[t][WORD_W-1-BYTE_W*SRC_ROW -: BYTE_W];
  end

  assign col_o = (last_i ? sub_w : mix_w) ^ key_i;
endmodule

// File: rtl/aes_tbox_round.sv
module aes_tbox_round
  import aes_tbox_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               last_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [STATE_W-1:0] rkey_i,
  output logic               valid_o,
  output logic [STATE_W-1:0] state_o
);
  logic [ROWS-1:0][COLS*BYTE_W-1:0] tbl_idx;
  logic [ROWS-1:0][COLS*WORD_W-1:0] tbl_word;
  logic [STATE_W-1:0]               next_state;

  // table t, port j reads row t of column (j+t) mod 4
  for (genvar t = 0; t < ROWS; t++) begin : g_tbl
    for (genvar j = 0; j < COLS; j++) begin : g_idx
      localparam int SRC_COL = (j + t) % COLS;
      assign tbl_idx[t][j*BYTE_W +: BYTE_W] =
        state_i[STATE_W-1-BYTE_W*(ROWS*SRC_COL+t) -: BYTE_W];
    end
    aes_tbox_rom #(.ROT(t), .PORTS(COLS)) u_rom (
      .idx_i (tbl_idx[t]),
      .word_o(tbl_word[t])
    );
  end

  for (genvar j = 0; j < COLS; j++) begin : g_col
    logic [ROWS-1:0][WORD_W-1:0] tw;
    for (genvar t = 0; t < ROWS; t++) begin : g_tw
      assign tw[t] = tbl_word[t][j*WORD_W +: WORD_W];
    end
    aes_tbox_column u_col (
      .tw_i  (tw),
      .key_i (rkey_i[STATE_W-1-WORD_W*j -: WORD_W]),
      .last_i(last_i),
      .col_o (next_state[STATE_W-1-WORD_W*j -: WORD_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      state_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) state_o <= next_state;
    end
  end
endmodule

// File: rtl/aes_tbox_round_chk.sv
module aes_tbox_round_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         last_i,
  input logic [127:0] state_i,
  input logic [127:0] rkey_i,
  input logic         valid_o,
  input logic [127:0] state_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R1: assert (!valid_o && state_o == '0);
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_o));

  assert_zero_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i && state_i == '0 && rkey_i == '0) |=> state_o == {16{8'h63}});
endmodule

bind aes_tbox_round aes_tbox_round_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .last_i (last_i),
  .state_i(state_i),
  .rkey_i (rkey_i),
  .valid_o(valid_o),
  .state_o(state_o)
);

// File: tb/tb_aes_tbox_round.sv
module tb_aes_tbox_round;
  localparam time CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         last_i = 1'b0;
  logic [127:0] state_i = '0;
  logic [127:0] rkey_i = '0;
  logic         valid_o;
  logic [127:0] state_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  aes_tbox_round dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // ---------- independent reference ----------
  function automatic logic [7:0] r_xt(input logic [7:0] b);
    return b[7] ? ((b << 1) ^ 8'h1b) : (b << 1);
  endfunction
  function automatic logic [7:0] r_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    for (int i = 7; i >= 0; i--) begin
      r = r_xt(r);
      if (b[i]) r ^= a;
    end
    return r;
  endfunction
  function automatic logic [7:0] r_sbox(input logic [7:0] a);
    logic [7:0] inv = 0, s;
    for (int b = 1; b < 256; b++) if (r_mul(a, 8'(b)) == 8'h01) inv = 8'(b);
    s = 8'h63;
    for (int i = 0; i < 8; i++)
      s[i] = s[i] ^ inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return s;
  endfunction
  function automatic logic [7:0] gb(input logic [127:0] s, input int c, input int r);
    return s[127-8*(4*c+r) -: 8];
  endfunction
  function automatic logic [127:0] ref_round(input logic [127:0] s, input logic [127:0] k,
                                             input bit last);
    logic [7:0] m [4][4];
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) m[c][r] = r_sbox(gb(s, (c + r) % 4, r));
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] v;
        if (last) v = m[c][r];
        else v = r_mul(m[c][r], 8'h02) ^ r_mul(m[c][(r+1)%4], 8'h03)
               ^ m[c][(r+2)%4] ^ m[c][(r+3)%4];
        o[127-8*(4*c+r) -: 8] = v;
      end
    return o ^ k;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample half a cycle after the registering edge
  task automatic run_round(input logic [127:0] s, input logic [127:0] k, input bit l,
                           output logic [127:0] q);
    state_i = s; rkey_i = k; last_i = l; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o === 1'b1, "R2 valid high", {127'b0, valid_o}, 128'd1);
    q = state_o;
  endtask

  task automatic idle_check(input logic [127:0] q);
    state_i = ~state_i; rkey_i = ~rkey_i;
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R2 valid low", {127'b0, valid_o}, 128'd0);
    chk(state_o === q, "R3 hold", state_o, q);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 128'd0, 128'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] q, q2, s, k, k2, e;
    logic [127:0] rk [11];
    void'($urandom(32'd1234));
    rk[1]  = 128'ha0fafe1788542cb123a339392a6c7605;
    rk[2]  = 128'hf2c295f27a96b9435935807a7359f67f;
    rk[3]  = 128'h3d80477d4716fe3e1e237e446d7a883b;
    rk[4]  = 128'hef44a541a8525b7fb671253bdb0bad00;
    rk[5]  = 128'hd4d1c6f87c839d87caf2b8bc11f915bc;
    rk[6]  = 128'h6d88a37a110b3efddbf98641ca0093fd;
    rk[7]  = 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f;
    rk[8]  = 128'head27321b58dbad2312bf5607f8d292f;
    rk[9]  = 128'hac7766f319fadc2128d12941575c006e;
    rk[10] = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

    @(negedge clk_i);
    chk(valid_o === 1'b0 && state_o === '0, "R1 reset", state_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6: all-zero last round
    run_round('0, '0, 1'b1, q);
    chk(q === {16{8'h63}}, "R6 zero last", q, {16{8'h63}});
    idle_check(q);

    // R5: single byte at column 1 row 1 lands at column 0 row 1 in last round
    s = '0; s[127-8*(4*1+1) -: 8] = 8'h53;
    e = {16{8'h63}}; e[127-8*(4*0+1) -: 8] = r_sbox(8'h53);
    run_round(s, '0, 1'b1, q);
    chk(q === e, "R5 row shift", q, e);
    // R5: column 3 row 3 lands at column 0 row 3
    s = '0; s[127-8*(4*3+3) -: 8] = 8'h01;
    e = {16{8'h63}}; e[127-8*(4*0+3) -: 8] = r_sbox(8'h01);
    run_round(s, '0, 1'b1, q);
    chk(q === e, "R5 row shift r3", q, e);

    // R7: key only XORs, both modes
    for (int m = 0; m < 2; m++) begin
      s = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      k2 = {$urandom, $urandom, $urandom, $urandom};
      run_round(s, k, m[0], q);
      run_round(s, k2, m[0], q2);
      chk((q ^ q2) === (k ^ k2), "R7 key xor", q ^ q2, k ^ k2);
    end

    // R4 / R6: random rounds, mixed modes, back to back
    for (int n = 0; n < 24; n++) begin
      bit l;
      s = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      l = ($urandom % 3) == 0;
      e = ref_round(s, k, l);
      run_round(s, k, l, q);
      chk(q === e, l ? "R6 last round" : "R4 full round", q, e);
      if (n % 6 == 5) idle_check(q);
    end

    // R4: all-ones state
    e = ref_round('1, '0, 1'b0);
    run_round('1, '0, 1'b0, q);
    chk(q === e, "R4 ones", q, e);

    // R8: chained example, every intermediate state
    s = 128'h3243f6a8885a308d313198a2e0370734 ^ 128'h2b7e151628aed2a6abf7158809cf4f3c;
    for (int r = 1; r <= 10; r++) begin
      e = ref_round(s, rk[r], r == 10);
      run_round(s, rk[r], r == 10, q);
      chk(q === e, "R8 chained round", q, e);
      s = q;
    end
    chk(s === 128'h3925841d02dc09fbdc118597196a0b32, "R8 ciphertext", s,
        128'h3925841d02dc09fbdc118597196a0b32);
    idle_check(s);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule